// File: doc/BRIEF.md
# Home Directory Controller

The block is the home node for a small set of memory blocks shared by several cache sites. For each block it keeps a directory state, a sharer bitmask, the owning site and the memory data word. Requests from caches arrive on one channel and replies from caches on a second channel. Each channel shows the head of an in-order queue, and the block pulses a pop line when it consumes that head. Messages to caches leave on one registered output port, at most one per cycle.

There are four block states. `BS_SHARED` means the block is held by the sites in the mask, or by none, and memory is valid. `BS_OWNED` means one site holds a modified copy. `BS_WAIT_INV` means invalidate acknowledgements are still pending from the sites in the mask. `BS_WAIT_DATA` means the block waits for the owner to return its data. When a request can only be served after other caches answer, the controller sends the forced requests and leaves the request at the head of its queue. Once the replies have resolved the block to `BS_SHARED`, the same request is evaluated again.

The sequencer has two states. In `FS_IDLE` it serves one reply or one request per cycle. In `FS_FANOUT` it sends the second and later invalidate requests of a fan-out, one per cycle, and it returns to `FS_IDLE` after the last one. The transitions are: shared grant, exclusive grant, invalidate fan-out, forced writeback, forced flush, acknowledgement collection, data return and the two silent consumes.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is `BS_SHARED` with an empty mask and data 0, `out_valid` is 0, and no pop is raised while both inputs are idle.
- R2: A shared request (`req_kind`=0) to a `BS_SHARED` block from a site that is not in its mask is popped in the same cycle. The site is added to the mask, and in the next cycle a shared reply (`out_kind`=0) carries the block data to that site.
- R3: An exclusive request (`req_kind`=1) to a `BS_SHARED` block whose mask holds no site other than the requester is popped. The block becomes `BS_OWNED` by the requester with an empty mask, and in the next cycle an exclusive reply (`out_kind`=1) carries the data.
- R4: A shared request from a site already in the mask is popped and produces no output message.
- R5: An exclusive request to a `BS_SHARED` block with other sharers is not popped. The block becomes `BS_WAIT_INV` with the other sharers as its pending mask. Starting the next cycle, one invalidate request (`out_kind`=2) goes to each pending site, one per cycle, in ascending site number.
- R6: An invalidate acknowledgement (`rep_kind`=0) to a `BS_SHARED` or `BS_WAIT_INV` block removes the sender from the mask. When a `BS_WAIT_INV` mask empties, the block returns to `BS_SHARED`, and the held exclusive request is then granted as in R3.
- R7: A request to a `BS_OWNED` block is not popped, except in the case of R8. The block becomes `BS_WAIT_DATA`, and the next cycle sends the owner a writeback request (`out_kind`=3) for a shared request or a flush request (`out_kind`=4) for an exclusive one.
- R8: An exclusive request from the owner of a `BS_OWNED` block is popped with no output message.
- R9: A writeback reply (`rep_kind`=1) to a `BS_OWNED` or `BS_WAIT_DATA` block stores `rep_data` and leaves the block `BS_SHARED` with the sender as its only sharer. A following shared or exclusive grant carries that data.
- R10: A flush reply (`rep_kind`=2) to a `BS_OWNED` or `BS_WAIT_DATA` block stores `rep_data` and leaves the block `BS_SHARED` with an empty mask.
- R11: A valid reply is always popped in its own cycle, including during a fan-out. A reply that does not fit the block state changes nothing.
- R12: No request is popped or acted on in a cycle with a valid reply, during `FS_FANOUT`, or while its block is `BS_WAIT_INV` or `BS_WAIT_DATA`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request queue head is present |
| req_kind | input | 1 | 0 shared request, 1 exclusive request |
| req_src | input | IW | Requesting site |
| req_addr | input | AW | Block index of request |
| req_pop | output | 1 | Request head consumed this cycle |
| rep_valid | input | 1 | Reply queue head is present |
| rep_kind | input | 2 | 0 invalidate ack, 1 writeback data, 2 flush data |
| rep_src | input | IW | Replying site |
| rep_addr | input | AW | Block index of reply |
| rep_data | input | DW | Data carried by writeback or flush |
| rep_pop | output | 1 | Reply head consumed this cycle |
| out_valid | output | 1 | Outgoing message valid |
| out_kind | output | 3 | 0 shared reply, 1 exclusive reply, 2 invalidate, 3 writeback req, 4 flush req |
| out_dst | output | IW | Destination site |
| out_addr | output | AW | Block index |
| out_data | output | DW | Block data for replies, 0 otherwise |

## Verification
Both pop lines are combinational, so they are due in the same cycle as the queue head they consume. The bench drives its inputs just after a falling edge and samples the pops one time unit later. Every outgoing message is registered and appears one cycle after the rising edge that committed its decision. The bench checks it at the next falling edge against a model prediction made in the previous cycle. An invalidate fan-out of k targets puts its messages out on k consecutive cycles, and a held request is granted one cycle after the reply that resolves its block, so the model also steps one cycle at a time.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;
    typedef enum logic [1:0] {
        BS_SHARED    = 2'd0,
        BS_OWNED     = 2'd1,
        BS_WAIT_INV  = 2'd2,
        BS_WAIT_DATA = 2'd3
    } blk_state_e;

    typedef enum logic {
        FS_IDLE   = 1'b0,
        FS_FANOUT = 1'b1
    } seq_state_e;

    localparam logic       RQ_SHARED = 1'b0;
    localparam logic       RQ_EXCL   = 1'b1;

    localparam logic [1:0] RK_INVACK = 2'd0;
    localparam logic [1:0] RK_WBDATA = 2'd1;
    localparam logic [1:0] RK_FLDATA = 2'd2;

    localparam logic [2:0] OK_SHREP  = 3'd0;
    localparam logic [2:0] OK_EXREP  = 3'd1;
    localparam logic [2:0] OK_INVREQ = 3'd2;
    localparam logic [2:0] OK_WBREQ  = 3'd3;
    localparam logic [2:0] OK_FLREQ  = 3'd4;
endpackage

// File: rtl/dir_lowbit.sv
module dir_lowbit #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dir_table.sv
module dir_table
    import dirctl_pkg::*;
#(
    parameter int NBLK  = 4,
    parameter int NSITE = 4,
    parameter int DW    = 16,
    parameter int AW    = 2,
    parameter int IW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_a,
    output blk_state_e       st_a,
    output logic [NSITE-1:0] shr_a,
    output logic [IW-1:0]    own_a,
    output logic [DW-1:0]    dat_a,
    input  logic [AW-1:0]    rd_b,
    output blk_state_e       st_b,
    output logic [NSITE-1:0] shr_b,
    output logic [IW-1:0]    own_b,
    output logic [DW-1:0]    dat_b,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  blk_state_e       w_st,
    input  logic [NSITE-1:0] w_shr,
    input  logic [IW-1:0]    w_own,
    input  logic [DW-1:0]    w_dat
);
    blk_state_e       st_all  [NBLK];
    logic [NSITE-1:0] shr_all [NBLK];
    logic [IW-1:0]    own_all [NBLK];
    logic [DW-1:0]    dat_all [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_ent
        blk_state_e       st_r;
        logic [NSITE-1:0] shr_r;
        logic [IW-1:0]    own_r;
        logic [DW-1:0]    dat_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_r  <= BS_SHARED;
                shr_r <= '0;
                own_r <= '0;
                dat_r <= '0;
            end else if (we && wa == AW'(g)) begin
                st_r  <= w_st;
                shr_r <= w_shr;
                own_r <= w_own;
                dat_r <= w_dat;
            end
        end

        assign st_all[g]  = st_r;
        assign shr_all[g] = shr_r;
        assign own_all[g] = own_r;
        assign dat_all[g] = dat_r;
    end

    assign st_a  = st_all[rd_a];
    assign shr_a = shr_all[rd_a];
    assign own_a = own_all[rd_a];
    assign dat_a = dat_all[rd_a];
    assign st_b  = st_all[rd_b];
    assign shr_b = shr_all[rd_b];
    assign own_b = own_all[rd_b];
    assign dat_b = dat_all[rd_b];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dirctl_pkg::*;
#(
    parameter int NBLK  = 4,
    parameter int NSITE = 4,
    parameter int DW    = 16,
    localparam int AW   = $clog2(NBLK),
    localparam int IW   = $clog2(NSITE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_kind,
    input  logic [IW-1:0] req_src,
    input  logic [AW-1:0] req_addr,
    output logic          req_pop,
    input  logic          rep_valid,
    input  logic [1:0]    rep_kind,
    input  logic [IW-1:0] rep_src,
    input  logic [AW-1:0] rep_addr,
    input  logic [DW-1:0] rep_data,
    output logic          rep_pop,
    output logic          out_valid,
    output logic [2:0]    out_kind,
    output logic [IW-1:0] out_dst,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);
    localparam logic [NSITE-1:0] ONE = {{(NSITE-1){1'b0}}, 1'b1};

    blk_state_e       st_a, st_b, w_st;
    logic [NSITE-1:0] shr_a, shr_b, w_shr;
    logic [IW-1:0]    own_a, own_b, w_own;
    logic [DW-1:0]    dat_a, dat_b, w_dat;
    logic             we;
    logic [AW-1:0]    wa;

    seq_state_e       fsm, fsm_n;
    logic [NSITE-1:0] fan_mask, fan_n;
    logic [AW-1:0]    fan_addr, fan_addr_n;

    logic             o_v_n;
    logic [2:0]       o_k_n;
    logic [IW-1:0]    o_dst_n;
    logic [AW-1:0]    o_addr_n;
    logic [DW-1:0]    o_dat_n;

    logic [NSITE-1:0] qbit, rbit, others, pick_mask, ack_left;
    logic [IW-1:0]    pick_idx;

    assign qbit      = ONE << req_src;
    assign rbit      = ONE << rep_src;
    assign others    = shr_a & ~qbit;
    assign ack_left  = shr_b & ~rbit;
    assign pick_mask = (fsm == FS_FANOUT) ? fan_mask : others;
    assign rep_pop   = rep_valid;

    dir_table #(
        .NBLK(NBLK), .NSITE(NSITE), .DW(DW), .AW(AW), .IW(IW)
    ) u_tab (
        .clk(clk), .rst_n(rst_n),
        .rd_a(req_addr), .st_a(st_a), .shr_a(shr_a), .own_a(own_a), .dat_a(dat_a),
        .rd_b(rep_addr), .st_b(st_b), .shr_b(shr_b), .own_b(own_b), .dat_b(dat_b),
        .we(we), .wa(wa), .w_st(w_st), .w_shr(w_shr), .w_own(w_own), .w_dat(w_dat)
    );

    dir_lowbit #(.N(NSITE), .IW(IW)) u_pick (
        .mask(pick_mask), .idx(pick_idx)
    );

    // sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm      <= FS_IDLE;
            fan_mask <= '0;
            fan_addr <= '0;
        end else begin
            fsm      <= fsm_n;
            fan_mask <= fan_n;
            fan_addr <= fan_addr_n;
        end
    end

    // next state, table update and outgoing message
    always_comb begin
        fsm_n      = fsm;
        fan_n      = fan_mask;
        fan_addr_n = fan_addr;
        req_pop    = 1'b0;
        we         = 1'b0;
        wa         = rep_addr;
        w_st       = st_b;
        w_shr      = shr_b;
        w_own      = own_b;
        w_dat      = dat_b;
        o_v_n      = 1'b0;
        o_k_n      = OK_SHREP;
        o_dst_n    = req_src;
        o_addr_n   = req_addr;
        o_dat_n    = '0;

        if (rep_valid) begin
            case (rep_kind)
                RK_INVACK: begin
                    if (st_b == BS_SHARED || st_b == BS_WAIT_INV) begin
                        we    = 1'b1;
                        w_shr = ack_left;
                        if (st_b == BS_WAIT_INV && ack_left == '0) w_st = BS_SHARED;
                    end
                end
                RK_WBDATA, RK_FLDATA: begin
                    if (st_b == BS_OWNED || st_b == BS_WAIT_DATA) begin
                        we    = 1'b1;
                        w_st  = BS_SHARED;
                        w_shr = (rep_kind == RK_WBDATA) ? rbit : '0;
                        w_dat = rep_data;
                    end
                end
                default: ;
            endcase
        end

        unique case (fsm)
            FS_FANOUT: begin
                o_v_n    = 1'b1;
                o_k_n    = OK_INVREQ;
                o_dst_n  = pick_idx;
                o_addr_n = fan_addr;
                fan_n    = fan_mask & ~(ONE << pick_idx);
                if (fan_n == '0) fsm_n = FS_IDLE;
            end
            FS_IDLE: begin
                if (req_valid && !rep_valid) begin
                    wa    = req_addr;
                    w_st  = st_a;
                    w_shr = shr_a;
                    w_own = own_a;
                    w_dat = dat_a;
                    unique case (st_a)
                        BS_SHARED: begin
                            if (req_kind == RQ_SHARED) begin
                                req_pop = 1'b1;
                                if ((shr_a & qbit) == '0) begin
                                    we      = 1'b1;
                                    w_shr   = shr_a | qbit;
                                    o_v_n   = 1'b1;
                                    o_k_n   = OK_SHREP;
                                    o_dat_n = dat_a;
                                end
                            end else if (others == '0) begin
                                req_pop = 1'b1;
                                we      = 1'b1;
                                w_st    = BS_OWNED;
                                w_own   = req_src;
                                w_shr   = '0;
                                o_v_n   = 1'b1;
                                o_k_n   = OK_EXREP;
                                o_dat_n = dat_a;
                            end else begin
                                we         = 1'b1;
                                w_st       = BS_WAIT_INV;
                                w_shr      = others;
                                o_v_n      = 1'b1;
                                o_k_n      = OK_INVREQ;
                                o_dst_n    = pick_idx;
                                fan_n      = others & ~(ONE << pick_idx);
                                fan_addr_n = req_addr;
                                if (fan_n != '0) fsm_n = FS_FANOUT;
                            end
                        end
                        BS_OWNED: begin
                            if (req_kind == RQ_EXCL && req_src == own_a) begin
                                req_pop = 1'b1;
                            end else begin
                                we      = 1'b1;
                                w_st    = BS_WAIT_DATA;
                                o_v_n   = 1'b1;
                                o_k_n   = (req_kind == RQ_EXCL) ? OK_FLREQ : OK_WBREQ;
                                o_dst_n = own_a;
                            end
                        end
                        BS_WAIT_INV, BS_WAIT_DATA: ;
                    endcase
                end
            end
        endcase
    end

    // registered outgoing message
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= OK_SHREP;
            out_dst   <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= o_v_n;
            out_kind  <= o_k_n;
            out_dst   <= o_dst_n;
            out_addr  <= o_addr_n;
            out_data  <= o_dat_n;
        end
    end

    // grants follow a consumed request and go back to its sender
    a_r2_shared_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == OK_SHREP) |->
            ($past(req_pop) && out_dst == $past(req_src) && out_addr == $past(req_addr)));

    a_r3_excl_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == OK_EXREP) |->
            ($past(req_pop) && out_dst == $past(req_src) && out_addr == $past(req_addr)));

    // invalidates of one fan-out leave in ascending site order
    a_r5_inv_order: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == OK_INVREQ && $past(out_valid) &&
         $past(out_kind) == OK_INVREQ && out_addr == $past(out_addr)) |->
            (out_dst > $past(out_dst)));

    // forced owner requests leave the triggering request in its queue
    a_r7_forced_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == OK_WBREQ || out_kind == OK_FLREQ)) |->
            $past(req_valid && !req_pop));

    // a request is never consumed in a cycle that carries a reply
    a_r12_reply_first: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> !req_pop);
endmodule

// File: tb/sim_dir_home_ctrl.sv
`timescale 1ns/1ps
module sim_dir_home_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_kind = 1'b0;
    logic [1:0]  req_src = '0, req_addr = '0;
    logic        req_pop;
    logic        rep_valid = 1'b0;
    logic [1:0]  rep_kind = '0, rep_src = '0, rep_addr = '0;
    logic [15:0] rep_data = '0;
    logic        rep_pop;
    logic        out_valid;
    logic [2:0]  out_kind;
    logic [1:0]  out_dst, out_addr;
    logic [15:0] out_data;

    always #2 clk = ~clk;

    dir_home_ctrl #(.NBLK(4), .NSITE(4), .DW(16)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_src(req_src), .req_addr(req_addr),
        .req_pop(req_pop),
        .rep_valid(rep_valid), .rep_kind(rep_kind), .rep_src(rep_src), .rep_addr(rep_addr),
        .rep_data(rep_data), .rep_pop(rep_pop),
        .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst), .out_addr(out_addr),
        .out_data(out_data)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model: 0 shared, 1 owned, 2 wait-inv, 3 wait-data
    int mst [4], msh [4], mown [4], mdat [4];
    int mfan = 0, mfaddr = 0;
    int ev = 0, ek = 0, ed = 0, ea = 0, edat = 0;
    int xq = 0;
    // held request at queue head
    int hv = 0, hk = 0, hs = 0, ha = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tagk(input int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            default: return "R7";
        endcase
    endfunction

    function automatic int lowest(input int m);
        for (int i = 3; i >= 0; i--) if (m[i]) lowest = i;
    endfunction

    task automatic model(input int rv, input int rk, input int rs, input int ra, input int rd);
        int bit_q, oth, lo;
        ev = 0; edat = 0; xq = 0;
        if (rv != 0) begin
            if (rk == 0 && (mst[ra] == 0 || mst[ra] == 2)) begin
                msh[ra] = msh[ra] & ~(1 << rs);
                if (mst[ra] == 2 && msh[ra] == 0) mst[ra] = 0;
            end else if ((rk == 1 || rk == 2) && (mst[ra] == 1 || mst[ra] == 3)) begin
                mst[ra] = 0;
                msh[ra] = (rk == 1) ? (1 << rs) : 0;
                mdat[ra] = rd;
            end
        end
        if (mfan != 0) begin
            lo = lowest(mfan);
            ev = 1; ek = 2; ed = lo; ea = mfaddr;
            mfan = mfan & ~(1 << lo);
        end else if (hv != 0 && rv == 0) begin
            bit_q = 1 << hs;
            ea = ha; ed = hs;
            if (mst[ha] == 0) begin
                if (hk == 0) begin
                    xq = 1;
                    if ((msh[ha] & bit_q) == 0) begin
                        msh[ha] = msh[ha] | bit_q;
                        ev = 1; ek = 0; edat = mdat[ha];
                    end
                end else begin
                    oth = msh[ha] & ~bit_q;
                    if (oth == 0) begin
                        xq = 1; mst[ha] = 1; mown[ha] = hs; msh[ha] = 0;
                        ev = 1; ek = 1; edat = mdat[ha];
                    end else begin
                        mst[ha] = 2; msh[ha] = oth;
                        lo = lowest(oth);
                        ev = 1; ek = 2; ed = lo;
                        mfan = oth & ~(1 << lo); mfaddr = ha;
                    end
                end
            end else if (mst[ha] == 1) begin
                if (hk == 1 && hs == mown[ha]) xq = 1;
                else begin
                    mst[ha] = 3;
                    ev = 1; ek = (hk == 1) ? 4 : 3; ed = mown[ha];
                end
            end
        end
    endtask

    task automatic chk_out();
        chk(out_valid == (ev != 0), (ev != 0) ? tagk(ek) : "R8", out_valid, ev);
        if (ev != 0 && out_valid) begin
            chk(out_kind == ek, tagk(ek), out_kind, ek);
            chk(out_dst == ed, tagk(ek), out_dst, ed);
            chk(out_addr == ea, tagk(ek), out_addr, ea);
            chk(out_data == edat, "R9", out_data, edat);
        end
    endtask

    // one cycle, entered and left right after a falling edge
    task automatic step(input int rv, input int rk, input int rs, input int ra, input int rd);
        chk_out();
        req_valid = (hv != 0); req_kind = hk[0]; req_src = hs[1:0]; req_addr = ha[1:0];
        rep_valid = (rv != 0); rep_kind = rk[1:0]; rep_src = rs[1:0]; rep_addr = ra[1:0];
        rep_data = rd[15:0];
        #1;
        model(rv, rk, rs, ra, rd);
        chk(rep_pop == (rv != 0), "R11", rep_pop, rv);
        chk(req_pop == (xq != 0), "R12", req_pop, xq);
        if (xq != 0) hv = 0;
        @(negedge clk);
    endtask

    task automatic run_req(input int k, input int s, input int a);
        hv = 1; hk = k; hs = s; ha = a;
        for (int n = 0; n < 30 && hv != 0; n++) step(0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin mst[i] = 0; msh[i] = 0; mown[i] = 0; mdat[i] = 0; end
        void'($urandom(32'd19));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!out_valid && !req_pop && !rep_pop, "R1", {out_valid, req_pop, rep_pop}, 0);
        @(negedge clk);

        run_req(0, 1, 0);                       // R2 first sharer
        run_req(0, 2, 0);                       // R2 second sharer
        run_req(0, 2, 0);                       // R4 repeated request
        chk(out_valid == 0, "R4", out_valid, 0);

        hv = 1; hk = 1; hs = 3; ha = 0;         // R5 fan-out to sites 1 and 2
        repeat (4) step(0, 0, 0, 0, 0);
        chk(hv == 1, "R5", hv, 1);
        step(1, 0, 1, 0, 0);                    // ack from 1
        step(1, 0, 2, 0, 0);                    // ack from 2, request held (R12)
        step(0, 0, 0, 0, 0);                    // R6 held request granted
        chk(out_valid && out_kind == 3'd1 && out_dst == 2'd3, "R6", out_kind, 1);

        run_req(1, 3, 0);                       // R8 owner repeats exclusive
        chk(out_valid == 0, "R8", out_valid, 0);

        hv = 1; hk = 0; hs = 0; ha = 0;         // R7 writeback forced
        step(0, 0, 0, 0, 0);
        step(1, 1, 3, 0, 16'hBEEF);             // R9 writeback data
        step(0, 0, 0, 0, 0);
        chk(out_valid && out_data == 16'hBEEF, "R9", out_data, 16'hBEEF);

        run_req(1, 1, 1);                       // R3 owned by site 1
        hv = 1; hk = 1; hs = 2; ha = 1;         // R7 flush forced
        step(0, 0, 0, 0, 0);
        step(1, 2, 1, 1, 16'h1234);             // R10 flush data
        step(0, 0, 0, 0, 0);
        chk(out_valid && out_kind == 3'd1 && out_data == 16'h1234, "R10", out_data, 16'h1234);
        chk(mst[1] == 1 && msh[1] == 0, "R10", msh[1], 0);

        for (int it = 0; it < 4000; it++) begin
            if (hv == 0 && ($urandom % 10) < 7) begin
                hv = 1; hk = $urandom % 2; hs = $urandom % 4; ha = $urandom % 4;
            end
            if (($urandom % 10) < 3)
                step(1, $urandom % 3, $urandom % 4, $urandom % 4, $urandom % 65536);
            else
                step(0, 0, 0, 0, 0);
        end
        chk_out();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL R12 watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule